// File: doc/BRIEF.md
# Multiprocessor UART Transmitter

This block is the transmit half of an asynchronous serial port. A single write strobe hands it one character. It then drives a start bit, 7 or 8 data bits, an optional address bit, an optional parity bit and one or two stop bits onto the serial line. The data bits go out in the order set by a direction input. Each bit lasts one period of an external bit-rate enable, and the block does not generate that rate itself.

Two one-shot controls change the next frame.

- The address control marks the frame as an address. In address-bit mode it does this with an extra bit after the data. In idle-line mode it does this with a long idle gap before the start bit.
- The break control replaces the character with a long low period followed by a high delimiter. In automatic baud-rate mode, the written byte is then sent as a normal synch character after the delimiter.

Both controls clear themselves when their frame is accepted. A busy output is high while a frame is being shifted out.

Top module: `uart_tx_mp`

## Requirements
- R1: After reset, `txd` is 1 and `busy`, `addr_armed` and `brk_armed` are 0. Whenever `busy` is 0, `txd` is 1.
- R2: A frame starts with a 0 start bit and ends with a 1 stop bit. With `msb_first`=0, the data bits go out from bit 0 upward.
- R3: With `msb_first`=1, the data bits go out from the highest data bit downward. With `char7`=1, only `wr_data[6:0]` is sent (7 data bits) and `wr_data[7]` is ignored.
- R4: With `two_stop`=1, the frame ends with two 1 stop bits instead of one.
- R5: With `par_en`=1, a parity bit follows the data bits (and the address bit, if present). With `par_even`=1, the sent data bits, the address bit and the parity bit together hold an even number of ones. With `par_even`=0, they hold an odd number.
- R6: With `mode`=2 (address-bit mode), one extra bit follows the data bits. It is 1 when the address control is armed and 0 otherwise.
- R7: With `mode`=1 (idle-line mode) and the address control armed, the line stays high for 11 bit times before the start bit. Unarmed frames have no extra gap.
- R8: With the break control armed and `mode` not 3, the frame is 13 low bit times followed by one high delimiter bit time. The written byte is ignored.
- R9: With the break control armed and `mode`=3, the break and delimiter of R8 are followed by a normal character carrying the written byte.
- R10: A pulse on `arm_addr` or `arm_brk` sets `addr_armed` or `brk_armed`. An accepted frame clears `brk_armed`, and a non-break accepted frame clears `addr_armed`. A set pulse in the accept cycle re-arms the control for the next frame.
- R11: `busy` rises in the cycle after an accepted write. It falls on the `bit_tick` that ends the last bit. `txd` changes only on `bit_tick` cycles. A write while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for a character |
| wr_data | input | DATA_W | Character to send |
| char7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| msb_first | input | 1 | 1: highest data bit first |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| two_stop | input | 1 | 1: two stop bits |
| mode | input | 2 | 0 plain, 1 idle-line, 2 address-bit, 3 auto-baud |
| arm_addr | input | 1 | Pulse: mark next frame as address |
| arm_brk | input | 1 | Pulse: make next frame a break |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| addr_armed | output | 1 | Address control pending |
| brk_armed | output | 1 | Break control pending |

## Verification
Characters with asymmetric bit patterns, such as 0xA5, 0x1E and 0xD3, are sent in both bit orders and both character lengths. A mirrored or truncated shift therefore shows up as a different bit string. Matching bytes are sent with even and odd parity, with and without an armed address bit, so parity that leaves out the address bit is told apart from correct parity. Break frames use the data values 0x00 and 0xFF, and the auto-baud case uses 0x55, which separates "data ignored" from "data appended". A write during an active frame checks that the frame is not disturbed and that no second frame follows.

// File: rtl/uart_tx_mp_pkg.sv
package uart_tx_mp_pkg;

  typedef enum logic [1:0] {
    TXM_PLAIN     = 2'd0,
    TXM_IDLE_ADDR = 2'd1,
    TXM_BIT_ADDR  = 2'd2,
    TXM_AUTOBAUD  = 2'd3
  } txm_e;

  typedef struct packed {
    logic short_char;
    logic msb_first;
    logic par_en;
    logic par_even;
    logic two_stop;
    txm_e mode;
  } tx_cfg_t;

endpackage

// File: rtl/uart_tx_mp_ctrl.sv
module uart_tx_mp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic set_addr,
  input  logic set_brk,
  output logic addr_q,
  output logic brk_q
);

  logic addr_d, brk_d;

  always_comb begin
    addr_d = addr_q;
    brk_d  = brk_q;
    if (accept) begin
      brk_d = 1'b0;
      if (!brk_q) addr_d = 1'b0;
    end
    if (set_addr) addr_d = 1'b1;
    if (set_brk)  brk_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      brk_q  <= brk_d;
    end
  end

  // R10
  brk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !set_brk) |=> !brk_q);

  // R10
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !brk_q && !set_addr) |=> !addr_q);

  // R10
  brk_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && brk_q && addr_q) |=> addr_q);

endmodule

// File: rtl/uart_tx_mp_framer.sv
module uart_tx_mp_framer
  import uart_tx_mp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BRK_LOW = 13,
  parameter int GAP_BITS = 11,
  parameter int SEQ_W   = 27,
  parameter int CNT_W   = 5
) (
  input  logic [DATA_W-1:0] data_i,
  input  tx_cfg_t           cfg,
  input  logic              addr_armed,
  input  logic              brk_armed,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [CNT_W-1:0]  len_o
);

  localparam logic [CNT_W-1:0] SEQ_W_C = CNT_W'(SEQ_W);

  logic [DATA_W-1:0] ord_src, ord, mask;
  logic [SEQ_W-1:0]  seq;
  logic [CNT_W-1:0]  pos;
  logic              addr_bit, par_raw, par_bit, send_char;

  always_comb begin
    ord_src = cfg.short_char ? {data_i[DATA_W-2:0], 1'b0} : data_i;
    for (int i = 0; i < DATA_W; i++)
      ord[i] = cfg.msb_first ? ord_src[DATA_W-1-i] : data_i[i];
    mask      = cfg.short_char ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    addr_bit  = (cfg.mode == TXM_BIT_ADDR) && addr_armed;
    par_raw   = (^(data_i & mask)) ^ addr_bit;
    par_bit   = cfg.par_even ? par_raw : ~par_raw;
    send_char = !brk_armed || (cfg.mode == TXM_AUTOBAUD);

    seq = {SEQ_W{1'b1}};
    pos = '0;
    if (brk_armed) begin
      for (int i = 0; i < BRK_LOW; i++) begin
        seq = {seq[SEQ_W-2:0], 1'b0};
        pos = pos + CNT_W'(1);
      end
      seq = {seq[SEQ_W-2:0], 1'b1};
      pos = pos + CNT_W'(1);
    end else if (addr_armed && cfg.mode == TXM_IDLE_ADDR) begin
      for (int i = 0; i < GAP_BITS; i++) begin
        seq = {seq[SEQ_W-2:0], 1'b1};
        pos = pos + CNT_W'(1);
      end
    end

    if (send_char) begin
      seq = {seq[SEQ_W-2:0], 1'b0};
      pos = pos + CNT_W'(1);
      for (int i = 0; i < DATA_W; i++) begin
        if (!(cfg.short_char && i == DATA_W-1)) begin
          seq = {seq[SEQ_W-2:0], ord[i]};
          pos = pos + CNT_W'(1);
        end
      end
      if (cfg.mode == TXM_BIT_ADDR) begin
        seq = {seq[SEQ_W-2:0], addr_bit};
        pos = pos + CNT_W'(1);
      end
      if (cfg.par_en) begin
        seq = {seq[SEQ_W-2:0], par_bit};
        pos = pos + CNT_W'(1);
      end
      seq = {seq[SEQ_W-2:0], 1'b1};
      pos = pos + CNT_W'(1);
      if (cfg.two_stop) begin
        seq = {seq[SEQ_W-2:0], 1'b1};
        pos = pos + CNT_W'(1);
      end
    end

    len_o = pos;
    seq_o = seq << (SEQ_W_C - pos);
  end

endmodule

// File: rtl/uart_tx_mp_shifter.sv
module uart_tx_mp_shifter #(
  parameter int SEQ_W = 27,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             wr_en,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             accept,
  output logic             busy,
  output logic             txd
);

  logic [SEQ_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic             busy_d, txd_d;

  assign accept = wr_en && !busy;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    busy_d = busy;
    txd_d  = txd;
    if (!busy) begin
      txd_d = 1'b1;
      if (wr_en) begin
        sreg_d = seq_i;
        len_d  = len_i;
        cnt_d  = '0;
        busy_d = 1'b1;
      end
    end else if (bit_tick) begin
      if (cnt_q == len_q) begin
        busy_d = 1'b0;
        txd_d  = 1'b1;
      end else begin
        txd_d  = sreg_q[SEQ_W-1];
        sreg_d = {sreg_q[SEQ_W-2:0], 1'b1};
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      cnt_q  <= '0;
      len_q  <= '0;
      busy   <= 1'b0;
      txd    <= 1'b1;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      busy   <= busy_d;
      txd    <= txd_d;
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R11
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  // R11
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> ($stable(cnt_q) && $stable(len_q) && busy));

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= len_q));

endmodule

// File: rtl/uart_tx_mp.sv
module uart_tx_mp
  import uart_tx_mp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BRK_LOW  = 13,
  parameter int GAP_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              char7,
  input  logic              msb_first,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              two_stop,
  input  logic [1:0]        mode,
  input  logic              arm_addr,
  input  logic              arm_brk,
  output logic              txd,
  output logic              busy,
  output logic              addr_armed,
  output logic              brk_armed
);

  localparam int FRAME_MAX = DATA_W + 5;
  localparam int LEAD_MAX  = (BRK_LOW + 1 > GAP_BITS) ? BRK_LOW + 1 : GAP_BITS;
  localparam int SEQ_W     = LEAD_MAX + FRAME_MAX;
  localparam int CNT_W     = $clog2(SEQ_W + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             accept;
  logic [SEQ_W-1:0] seq;
  logic [CNT_W-1:0] len;
  tx_cfg_t          cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    cfg.short_char = char7;
    cfg.msb_first  = msb_first;
    cfg.par_en     = par_en;
    cfg.par_even   = par_even;
    cfg.two_stop   = two_stop;
    cfg.mode       = txm_e'(mode);
  end

  uart_tx_mp_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .accept   (accept),
    .set_addr (arm_addr),
    .set_brk  (arm_brk),
    .addr_q   (addr_armed),
    .brk_q    (brk_armed)
  );

  uart_tx_mp_framer #(
    .DATA_W   (DATA_W),
    .BRK_LOW  (BRK_LOW),
    .GAP_BITS (GAP_BITS),
    .SEQ_W    (SEQ_W),
    .CNT_W    (CNT_W)
  ) i_framer (
    .data_i     (wr_data),
    .cfg        (cfg),
    .addr_armed (addr_armed),
    .brk_armed  (brk_armed),
    .seq_o      (seq),
    .len_o      (len)
  );

  uart_tx_mp_shifter #(
    .SEQ_W (SEQ_W),
    .CNT_W (CNT_W)
  ) i_shifter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_tick (bit_tick),
    .wr_en    (wr_en),
    .seq_i    (seq),
    .len_i    (len),
    .accept   (accept),
    .busy     (busy),
    .txd      (txd)
  );

endmodule

// File: tb/test_uart_tx_mp.sv
module test_uart_tx_mp;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, bit_tick, wr_en;
  logic [7:0] wr_data;
  logic       char7, msb_first, par_en, par_even, two_stop;
  logic [1:0] mode;
  logic       arm_addr, arm_brk;
  logic       txd, busy, addr_armed, brk_armed;

  uart_tx_mp i_uart_tx_mp (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .char7(char7), .msb_first(msb_first),
    .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
    .mode(mode), .arm_addr(arm_addr), .arm_brk(arm_brk),
    .txd(txd), .busy(busy), .addr_armed(addr_armed), .brk_armed(brk_armed)
  );

  int total = 0;
  int bad   = 0;

  // bit-rate enable every 4 clocks; log one line sample per bit time
  int   tick_cnt;
  int   log_n;
  logic log_bits [0:1023];

  always @(negedge clk) begin
    if (!rst_n) begin
      tick_cnt <= 0;
      bit_tick <= 1'b0;
      log_n    <= 0;
    end else begin
      if (bit_tick && busy) begin
        log_bits[log_n % 1024] <= txd;
        log_n <= log_n + 1;
      end
      tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
      bit_tick <= (tick_cnt == 3);
    end
  end

  logic [63:0] exp_v;
  int          exp_n;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic push(logic b);
    exp_v[exp_n] = b;
    exp_n++;
  endtask

  // expected frame from the requirement text
  task automatic model_char(logic [7:0] d, logic addr_on);
    int  nb;
    logic ones;
    nb   = char7 ? 7 : 8;
    ones = 1'b0;
    push(1'b0);
    for (int i = 0; i < nb; i++) begin
      logic b;
      b = msb_first ? d[nb-1-i] : d[i];
      ones ^= b;
      push(b);
    end
    if (mode == 2'd2) begin
      push(addr_on);
      ones ^= addr_on;
    end
    if (par_en) push(par_even ? ones : ~ones);
    push(1'b1);
    if (two_stop) push(1'b1);
  endtask

  task automatic model_clear();
    exp_v = '0;
    exp_n = 0;
  endtask

  task automatic model_break();
    for (int i = 0; i < 13; i++) push(1'b0);
    push(1'b1);
  endtask

  task automatic write_byte(logic [7:0] d);
    @(posedge clk);
    while (tick_cnt != 1) @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic run_frame(string tag, logic [7:0] d);
    int start;
    logic [63:0] got;
    int n;
    start = log_n;
    write_byte(d);
    do @(negedge clk); while (busy === 1'b1);
    @(negedge clk);
    n   = log_n - start;
    got = '0;
    for (int i = 0; i < n && i < 64; i++) got[i] = log_bits[(start + i) % 1024];
    chk({tag, " length"}, 64'(n), 64'(exp_n));
    chk({tag, " bits"}, got, exp_v);
  endtask

  task automatic arm(logic a, logic b);
    @(negedge clk);
    arm_addr = a;
    arm_brk  = b;
    @(negedge clk);
    arm_addr = 1'b0;
    arm_brk  = 1'b0;
  endtask

  task automatic set_cfg(logic c7, logic msb, logic pe, logic pev, logic ts, logic [1:0] m);
    char7 = c7; msb_first = msb; par_en = pe; par_even = pev; two_stop = ts; mode = m;
  endtask

  task automatic test_reset();
    chk("R1 txd after reset", 64'(txd), 64'd1);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 armed after reset", 64'({addr_armed, brk_armed}), 64'd0);
  endtask

  task automatic test_basic();
    set_cfg(0, 0, 0, 0, 0, 2'd0);
    model_clear(); model_char(8'hA5, 1'b0);
    run_frame("R2 8N1 lsb A5", 8'hA5);
  endtask

  task automatic test_order();
    set_cfg(0, 1, 0, 0, 0, 2'd0);
    model_clear(); model_char(8'h1E, 1'b0);
    run_frame("R3 msb first 1E", 8'h1E);
    set_cfg(1, 0, 0, 0, 0, 2'd0);
    model_clear(); model_char(8'hD3, 1'b0);
    run_frame("R3 7-bit lsb D3", 8'hD3);
    set_cfg(1, 1, 0, 0, 0, 2'd0);
    model_clear(); model_char(8'hD3, 1'b0);
    run_frame("R3 7-bit msb D3", 8'hD3);
  endtask

  task automatic test_stop();
    set_cfg(0, 0, 0, 0, 1, 2'd0);
    model_clear(); model_char(8'h81, 1'b0);
    run_frame("R4 two stop 81", 8'h81);
  endtask

  task automatic test_parity();
    set_cfg(0, 0, 1, 1, 0, 2'd0);
    model_clear(); model_char(8'h07, 1'b0);
    run_frame("R5 even parity 07", 8'h07);
    set_cfg(0, 0, 1, 0, 0, 2'd0);
    model_clear(); model_char(8'h07, 1'b0);
    run_frame("R5 odd parity 07", 8'h07);
  endtask

  task automatic test_addr_bit();
    set_cfg(0, 0, 1, 1, 0, 2'd2);
    arm(1'b1, 1'b0);
    chk("R10 addr armed", 64'(addr_armed), 64'd1);
    model_clear(); model_char(8'h5A, 1'b1);
    run_frame("R6 R5 address bit set 5A", 8'h5A);
    chk("R10 addr cleared after frame", 64'(addr_armed), 64'd0);
    model_clear(); model_char(8'h5A, 1'b0);
    run_frame("R6 address bit clear 5A", 8'h5A);
  endtask

  task automatic test_idle_line();
    set_cfg(0, 0, 0, 0, 0, 2'd1);
    arm(1'b1, 1'b0);
    model_clear();
    for (int i = 0; i < 11; i++) push(1'b1);
    model_char(8'h3C, 1'b0);
    run_frame("R7 idle gap before address 3C", 8'h3C);
    chk("R10 addr cleared idle mode", 64'(addr_armed), 64'd0);
    model_clear(); model_char(8'h3C, 1'b0);
    run_frame("R7 no gap when unarmed", 8'h3C);
  endtask

  task automatic test_break();
    set_cfg(0, 0, 0, 0, 0, 2'd0);
    arm(1'b0, 1'b1);
    chk("R10 brk armed", 64'(brk_armed), 64'd1);
    model_clear(); model_break();
    run_frame("R8 break with 00", 8'h00);
    chk("R10 brk cleared", 64'(brk_armed), 64'd0);
    arm(1'b0, 1'b1);
    model_clear(); model_break();
    run_frame("R8 break ignores FF", 8'hFF);
  endtask

  task automatic test_autobaud();
    set_cfg(0, 0, 0, 0, 0, 2'd3);
    arm(1'b0, 1'b1);
    model_clear(); model_break(); model_char(8'h55, 1'b0);
    run_frame("R9 break plus synch 55", 8'h55);
    chk("R10 brk cleared autobaud", 64'(brk_armed), 64'd0);
  endtask

  task automatic test_busy();
    int start, n, high_cnt;
    logic [63:0] got;
    set_cfg(0, 0, 0, 0, 0, 2'd0);
    model_clear(); model_char(8'h0F, 1'b0);
    start = log_n;
    write_byte(8'h0F);
    chk("R11 busy after write", 64'(busy), 64'd1);
    repeat (10) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hF0;
    @(negedge clk);
    wr_en = 1'b0;
    do @(negedge clk); while (busy === 1'b1);
    @(negedge clk);
    n   = log_n - start;
    got = '0;
    for (int i = 0; i < n && i < 64; i++) got[i] = log_bits[(start + i) % 1024];
    chk("R11 frame intact under busy write", got, exp_v);
    chk("R11 length under busy write", 64'(n), 64'(exp_n));
    high_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy === 1'b0 && txd === 1'b1) high_cnt++;
    end
    chk("R11 no second frame", 64'(high_cnt), 64'd40);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    arm_addr = 1'b0; arm_brk = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 2'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_basic();
    test_order();
    test_stop();
    test_parity();
    test_addr_bit();
    test_idle_line();
    test_break();
    test_autobaud();
    test_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule